// File: doc/BRIEF.md
# I2C Bus State and Condition Control

This block watches the SCL and SDA lines of an I2C bus and keeps a flag that says whether the bus is occupied. The flag goes up when a start condition is seen and drops when a stop condition is seen. Both lines pass through a synchronizer first. Condition detection then compares each synchronized sample with the one taken a cycle earlier.

Software drives the block through a single register write. The write carries a requested busy value and a command gate bit. A write with the gate bit at 0 asks a master bit-engine for a start, a repeated start or a stop condition. The kind of condition depends on the requested value, on the current bus state and on the master and transmit mode inputs. Each request reaches the bit-engine as a one-cycle pulse.

The block also keeps an interrupt request flag. Strobes from the byte engine and the arbitration logic set it, and so does a detected stop condition. Software clears it with a read followed by a write of 0. A transfer engine can clear it in one cycle with a dedicated strobe.

Top module: `i2c_busctl`

## Requirements
- R1: A falling SDA while SCL stays high is a start condition and sets `busBusy` to 1. The flag changes on the third rising clock edge after the line change, and it is still 0 on the second. SDA changes while SCL is low do not affect `busBusy`.
- R2: A rising SDA while SCL stays high is a stop condition. On the same edge that clears `busBusy` to 0 (the third after the line change), it also sets `irqOut` to 1.
- R3: A write (`regWrEn`=1) with `regWrBusy`=1 and `regWrGateN`=0 is a start request. With `modeMaster`=1, `modeTransmit`=1 and `busBusy`=0, `startReq` is high for exactly the one cycle that follows the write edge.
- R4: The same write while `busBusy`=1 pulses `restartReq` instead of `startReq`.
- R5: A write with `regWrBusy`=0 and `regWrGateN`=0 while `modeMaster`=1 pulses `stopReq` for one cycle.
- R6: A start request with `modeMaster`=0 or `modeTransmit`=0 is ignored. A stop request with `modeMaster`=0 is ignored. An ignored request pulses no request output.
- R7: A write with `regWrGateN`=1 produces no request output and leaves `busBusy` unchanged.
- R8: `evXferDone` always sets `irqOut` on the next edge. `evAddrMatch` sets it only when `modeMaster`=0 and `modeTransmit`=0. `evArbLost` sets it only when `modeMaster`=1 and `modeTransmit`=1.
- R9: A write with `regWrIrqBit`=0 clears `irqOut` only if an earlier `regRdEn` cycle saw `irqOut`=1 and no write has come between. Any other write of 0 leaves the flag set.
- R10: An `irqAutoClr` pulse clears `irqOut` on the next edge.
- R11: When a set event and a clear (by write or by `irqAutoClr`) fall in the same cycle, `irqOut` stays 1.
- R12: After reset `busBusy`=0, `irqOut`=0 and every request output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line sample |
| sdaIn | input | 1 | Bus data line sample |
| regWrEn | input | 1 | Control register write strobe |
| regWrBusy | input | 1 | Written bus-busy value (1 asks for start, 0 for stop) |
| regWrGateN | input | 1 | Command gate; a request is made only when 0 |
| regWrIrqBit | input | 1 | Written interrupt flag value |
| regRdEn | input | 1 | Control register read strobe |
| modeMaster | input | 1 | 1 = master mode, 0 = slave mode |
| modeTransmit | input | 1 | 1 = transmit, 0 = receive |
| evXferDone | input | 1 | Data transfer finished strobe |
| evAddrMatch | input | 1 | Own or general-call address detected strobe |
| evArbLost | input | 1 | Arbitration lost strobe |
| irqAutoClr | input | 1 | Clear the interrupt flag without the CPU |
| busBusy | output | 1 | Bus occupied flag |
| irqOut | output | 1 | Interrupt request flag |
| startReq | output | 1 | One-cycle request for a start condition |
| restartReq | output | 1 | One-cycle request for a repeated start |
| stopReq | output | 1 | One-cycle request for a stop condition |

## Verification
Two pairs of functions can land on the same edge. The first is setting and clearing the interrupt flag. The bench drives a transfer-done strobe together with a write of 0 after a valid read, and again together with the auto-clear strobe, and expects the flag to stay 1. The second is the arming read and the clearing write. A read made while the flag is 0, followed by an event and a write of 0, must not clear the flag. Every expected value is queued for a given cycle, and a monitor compares it against all five outputs at that cycle.

// File: rtl/i2c_busctl_pkg.sv
package i2c_busctl_pkg;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic reqStart;
    logic reqRestart;
    logic reqStop;
    logic setIrq;
    logic clrIrq;
  } ctlStb_t;

  // status returned by the datapath
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic busy;
    logic irq;
  } busStat_t;

endpackage

// File: rtl/i2c_busctl_dp.sv
module i2c_busctl_dp
  import i2c_busctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  ctlStb_t  stb,
  output busStat_t stat,
  output logic     busBusy,
  output logic     irqOut,
  output logic     startReq,
  output logic     restartReq,
  output logic     stopReq
);

  localparam int LINES = 2;
  localparam int SCL_IDX = 1;
  localparam int SDA_IDX = 0;

  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineSync;
  logic [LINES-1:0] linePrev;

  assign lineRaw = {sclIn, sdaIn};

  // one synchronizer chain per bus line; idle level of the bus is high
  for (genvar ln = 0; ln < LINES; ln++) begin : g_sync
    logic [SYNC_STAGES-1:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= '1;
      else       chainQ <= {chainQ[SYNC_STAGES-2:0], lineRaw[ln]};
    end
    assign lineSync[ln] = chainQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '1;
    else       linePrev <= lineSync;
  end

  logic sclHigh;
  logic sdaFall;
  logic sdaRise;
  logic startSeen;
  logic stopSeen;

  assign sclHigh   = lineSync[SCL_IDX] & linePrev[SCL_IDX];
  assign sdaFall   = linePrev[SDA_IDX] & ~lineSync[SDA_IDX];
  assign sdaRise   = ~linePrev[SDA_IDX] & lineSync[SDA_IDX];
  assign startSeen = sclHigh & sdaFall;
  assign stopSeen  = sclHigh & sdaRise;

  // bus occupied flag follows the line conditions only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busBusy <= 1'b0;
    else if (startSeen) busBusy <= 1'b1;
    else if (stopSeen)  busBusy <= 1'b0;
  end

  // interrupt flag: a set beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           irqOut <= 1'b0;
    else if (stb.setIrq) irqOut <= 1'b1;
    else if (stb.clrIrq) irqOut <= 1'b0;
  end

  // request pulses toward the master bit engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReq   <= 1'b0;
      restartReq <= 1'b0;
      stopReq    <= 1'b0;
    end else begin
      startReq   <= stb.reqStart;
      restartReq <= stb.reqRestart;
      stopReq    <= stb.reqStop;
    end
  end

  always_comb begin
    stat.startSeen = startSeen;
    stat.stopSeen  = stopSeen;
    stat.busy      = busBusy;
    stat.irq       = irqOut;
  end

endmodule

// File: rtl/i2c_busctl_ctl.sv
module i2c_busctl_ctl
  import i2c_busctl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     regWrEn,
  input  logic     regWrBusy,
  input  logic     regWrGateN,
  input  logic     regWrIrqBit,
  input  logic     regRdEn,
  input  logic     modeMaster,
  input  logic     modeTransmit,
  input  logic     evXferDone,
  input  logic     evAddrMatch,
  input  logic     evArbLost,
  input  logic     irqAutoClr,
  input  busStat_t stat,
  output ctlStb_t  stb
);

  logic cmdWrite;
  logic masterTx;
  logic slaveRx;
  logic clrArmed;
  logic irqWriteClr;

  assign cmdWrite = regWrEn & ~regWrGateN;
  assign masterTx = modeMaster & modeTransmit;
  assign slaveRx  = ~modeMaster & ~modeTransmit;

  // armed after a read that saw the flag set; any write or a dropped flag disarms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrArmed <= 1'b0;
    else       clrArmed <= (regRdEn & stat.irq) | (clrArmed & ~regWrEn & stat.irq);
  end

  assign irqWriteClr = regWrEn & ~regWrIrqBit & clrArmed;

  always_comb begin
    stb            = '0;
    stb.reqStart   = cmdWrite & regWrBusy & masterTx & ~stat.busy;
    stb.reqRestart = cmdWrite & regWrBusy & masterTx & stat.busy;
    stb.reqStop    = cmdWrite & ~regWrBusy & modeMaster;
    stb.setIrq     = evXferDone
                   | (evAddrMatch & slaveRx)
                   | (evArbLost & masterTx)
                   | stat.stopSeen;
    stb.clrIrq     = irqAutoClr | irqWriteClr;
  end

endmodule

// File: rtl/i2c_busctl.sv
module i2c_busctl
  import i2c_busctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic regWrEn,
  input  logic regWrBusy,
  input  logic regWrGateN,
  input  logic regWrIrqBit,
  input  logic regRdEn,
  input  logic modeMaster,
  input  logic modeTransmit,
  input  logic evXferDone,
  input  logic evAddrMatch,
  input  logic evArbLost,
  input  logic irqAutoClr,
  output logic busBusy,
  output logic irqOut,
  output logic startReq,
  output logic restartReq,
  output logic stopReq
);

  ctlStb_t  stb;
  busStat_t stat;
  logic     startSeen;
  logic     stopSeen;

  i2c_busctl_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regWrBusy    (regWrBusy),
    .regWrGateN   (regWrGateN),
    .regWrIrqBit  (regWrIrqBit),
    .regRdEn      (regRdEn),
    .modeMaster   (modeMaster),
    .modeTransmit (modeTransmit),
    .evXferDone   (evXferDone),
    .evAddrMatch  (evAddrMatch),
    .evArbLost    (evArbLost),
    .irqAutoClr   (irqAutoClr),
    .stat         (stat),
    .stb          (stb)
  );

  i2c_busctl_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .stb        (stb),
    .stat       (stat),
    .busBusy    (busBusy),
    .irqOut     (irqOut),
    .startReq   (startReq),
    .restartReq (restartReq),
    .stopReq    (stopReq)
  );

  assign startSeen = stat.startSeen;
  assign stopSeen  = stat.stopSeen;

endmodule

// File: rtl/i2c_busctl_chk.sv
module i2c_busctl_chk (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic regWrBusy,
  input logic regWrGateN,
  input logic modeMaster,
  input logic modeTransmit,
  input logic evXferDone,
  input logic startSeen,
  input logic stopSeen,
  input logic busBusy,
  input logic irqOut,
  input logic startReq,
  input logic restartReq,
  input logic stopReq
);

  // R1
  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> busBusy);

  // R2
  a_r2_stop_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (!busBusy && irqOut));

  // R3, R4, R6
  a_r6_start_needs_master_tx: assert property (@(posedge clk) disable iff (!rstN)
    (startReq || restartReq) |-> $past(regWrEn && !regWrGateN && regWrBusy && modeMaster && modeTransmit));

  // R5, R6
  a_r5_stop_needs_master: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> $past(regWrEn && !regWrGateN && !regWrBusy && modeMaster));

  // R3, R4
  a_r4_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startReq, restartReq, stopReq}));

  // R8, R11
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    evXferDone |=> irqOut);

endmodule

bind i2c_busctl i2c_busctl_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regWrBusy    (regWrBusy),
  .regWrGateN   (regWrGateN),
  .modeMaster   (modeMaster),
  .modeTransmit (modeTransmit),
  .evXferDone   (evXferDone),
  .startSeen    (startSeen),
  .stopSeen     (stopSeen),
  .busBusy      (busBusy),
  .irqOut       (irqOut),
  .startReq     (startReq),
  .restartReq   (restartReq),
  .stopReq      (stopReq)
);

// File: tb/i2c_busctl_test.sv
module i2c_busctl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic regWrEn = 1'b0, regWrBusy = 1'b0, regWrGateN = 1'b1, regWrIrqBit = 1'b1, regRdEn = 1'b0;
  logic modeMaster = 1'b0, modeTransmit = 1'b0;
  logic evXferDone = 1'b0, evAddrMatch = 1'b0, evArbLost = 1'b0, irqAutoClr = 1'b0;
  logic busBusy, irqOut, startReq, restartReq, stopReq;

  always #5 clk = ~clk;

  i2c_busctl uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .regWrEn(regWrEn), .regWrBusy(regWrBusy), .regWrGateN(regWrGateN),
    .regWrIrqBit(regWrIrqBit), .regRdEn(regRdEn),
    .modeMaster(modeMaster), .modeTransmit(modeTransmit),
    .evXferDone(evXferDone), .evAddrMatch(evAddrMatch), .evArbLost(evArbLost),
    .irqAutoClr(irqAutoClr),
    .busBusy(busBusy), .irqOut(irqOut), .startReq(startReq),
    .restartReq(restartReq), .stopReq(stopReq)
  );

  typedef struct {
    int        cyc;
    string     tag;
    logic [4:0] val; // {busy, irq, start, restart, stop}
  } expItem_t;

  expItem_t expQ[$];
  int cycleCnt = 0;
  int nChecks = 0;
  int nFails = 0;
  logic mBusy = 1'b0;
  logic mIrq = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // driver side: queue the expected outputs for a future cycle
  task automatic expectAt(input int d, input string tag,
                          input logic s, input logic rs, input logic sp);
    expItem_t it;
    it.cyc = cycleCnt + d;
    it.tag = tag;
    it.val = {mBusy, mIrq, s, rs, sp};
    expQ.push_back(it);
  endtask

  // monitor side: compare every due item at the falling edge
  always @(negedge clk) begin
    logic [4:0] act;
    act = {busBusy, irqOut, startReq, restartReq, stopReq};
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].cyc == cycleCnt) begin
        nChecks++;
        if (act !== expQ[i].val) begin
          nFails++;
          $display("FAIL %s cycle %0d: actual busy/irq/start/restart/stop=%b expected=%b",
                   expQ[i].tag, cycleCnt, act, expQ[i].val);
        end
        expQ.delete(i);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic b, input logic g, input logic q);
    regWrEn = 1'b1; regWrBusy = b; regWrGateN = g; regWrIrqBit = q;
    @(negedge clk);
    regWrEn = 1'b0; regWrGateN = 1'b1; regWrIrqBit = 1'b1;
  endtask

  task automatic rd();
    regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulseEv(input int which);
    case (which)
      0: evXferDone = 1'b1;
      1: evAddrMatch = 1'b1;
      2: evArbLost = 1'b1;
      default: irqAutoClr = 1'b1;
    endcase
    @(negedge clk);
    evXferDone = 1'b0; evAddrMatch = 1'b0; evArbLost = 1'b0; irqAutoClr = 1'b0;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    expectAt(1, "R12 reset", 0, 0, 0);
    idle(2);

    // R1: start on the lines
    sdaIn = 1'b0;
    expectAt(2, "R1 latency", 0, 0, 0);
    mBusy = 1'b1;
    expectAt(3, "R1 start", 0, 0, 0);
    idle(5);
    // data changes with SCL low are not conditions
    sclIn = 1'b0; idle(4);
    sdaIn = 1'b1; idle(4);
    sdaIn = 1'b0; idle(4);
    sclIn = 1'b1; idle(4);
    expectAt(1, "R1 scl low ignored", 0, 0, 0);
    idle(2);
    // R2: stop
    sdaIn = 1'b1;
    mBusy = 1'b0; mIrq = 1'b1;
    expectAt(3, "R2 stop", 0, 0, 0);
    idle(5);

    // R9: write 0 without read leaves flag
    expectAt(1, "R9 no read", 0, 0, 0);
    wr(1'b0, 1'b1, 1'b0);
    idle(1);
    rd();
    mIrq = 1'b0;
    expectAt(1, "R9 read then write", 0, 0, 0);
    wr(1'b0, 1'b1, 1'b0);
    idle(1);

    // R3: start request on a free bus
    modeMaster = 1'b1; modeTransmit = 1'b1;
    expectAt(1, "R3 start pulse", 1, 0, 0);
    expectAt(2, "R3 pulse ends", 0, 0, 0);
    wr(1'b1, 1'b0, 1'b1);
    idle(2);
    sdaIn = 1'b0;
    mBusy = 1'b1;
    idle(5);
    // R4: repeated start while busy
    expectAt(1, "R4 restart pulse", 0, 1, 0);
    expectAt(2, "R4 pulse ends", 0, 0, 0);
    wr(1'b1, 1'b0, 1'b1);
    idle(2);
    // R7: gate set, nothing happens
    expectAt(1, "R7 gated start", 0, 0, 0);
    wr(1'b1, 1'b1, 1'b1);
    expectAt(1, "R7 gated stop", 0, 0, 0);
    wr(1'b0, 1'b1, 1'b1);
    // R5: stop request
    expectAt(1, "R5 stop pulse", 0, 0, 1);
    expectAt(2, "R5 pulse ends", 0, 0, 0);
    wr(1'b0, 1'b0, 1'b1);
    idle(2);
    // R6: mode gating
    modeTransmit = 1'b0;
    expectAt(1, "R6 start master rx", 0, 0, 0);
    wr(1'b1, 1'b0, 1'b1);
    modeMaster = 1'b0; modeTransmit = 1'b1;
    expectAt(1, "R6 start slave tx", 0, 0, 0);
    wr(1'b1, 1'b0, 1'b1);
    expectAt(1, "R6 stop slave", 0, 0, 0);
    wr(1'b0, 1'b0, 1'b1);
    idle(1);

    // R8: event qualification
    mIrq = 1'b1;
    expectAt(1, "R8 xfer done", 0, 0, 0);
    pulseEv(0);
    mIrq = 1'b0;
    expectAt(1, "R10 auto clear", 0, 0, 0);
    pulseEv(3);
    modeMaster = 1'b1; modeTransmit = 1'b0;
    expectAt(1, "R8 addr in master", 0, 0, 0);
    pulseEv(1);
    modeMaster = 1'b0;
    mIrq = 1'b1;
    expectAt(1, "R8 addr in slave rx", 0, 0, 0);
    pulseEv(1);
    mIrq = 1'b0;
    pulseEv(3);
    expectAt(1, "R8 arb lost in slave", 0, 0, 0);
    pulseEv(2);
    modeMaster = 1'b1; modeTransmit = 1'b1;
    mIrq = 1'b1;
    expectAt(1, "R8 arb lost master tx", 0, 0, 0);
    pulseEv(2);

    // R11: set and write-clear in one cycle
    rd();
    evXferDone = 1'b1;
    expectAt(1, "R11 set beats write clear", 0, 0, 0);
    wr(1'b1, 1'b1, 1'b0);
    evXferDone = 1'b0;
    // R11: set and auto clear in one cycle
    evXferDone = 1'b1;
    expectAt(1, "R11 set beats auto clear", 0, 0, 0);
    pulseEv(3);
    mIrq = 1'b0;
    pulseEv(3);

    // R9: a read that saw 0 does not arm the clear
    rd();
    mIrq = 1'b1;
    pulseEv(0);
    expectAt(1, "R9 stale read", 0, 0, 0);
    wr(1'b1, 1'b1, 1'b0);
    idle(3);

    done = 1'b1;
    finishRun();
  end

endmodule